// File: doc/BRIEF.md
# Trigger Word Latch with OR-Sum Capture

This block receives a word of trigger lines and republishes it either as a live copy or as a frozen snapshot. A latch strobe controls which of the two it is. While the strobe is high the output follows the inputs. The falling edge takes a snapshot, and the snapshot is kept for as long as the strobe stays low. A fan-out mode bypasses the snapshot entirely, so the block then acts as a plain registered buffer.

Alongside the data path, the block forms the OR of every trigger line. It presents that OR live as a global trigger and also keeps a held copy of it. In the default modes the held copy is taken on the rising edge of a separate global strobe and is cleared by a level clear input. In the held-sum mode the held copy is instead taken on the same falling edge that freezes the data word. An optional setting lets the latch strobe act only while some trigger line is set. A blanking input forces the three indicator outputs dark.

All strobes are sampled on the system clock. Their edges are found by comparing the registered level with the level registered one clock earlier.

Top module: `trig_latch_sum`

## Requirements
- R1: A synchronous `rst` clears `data_o`, `sum_held_o` and the registered strobe levels. At the first clock edge after reset is released, `data_o` and `sum_held_o` are 0.
- R2: The drive level is `latch_stb_i`, or `latch_stb_i & |trig_i` when `gate_sum_i` is 1. It is registered on every clock. While that registered level is 1, every clock edge loads `trig_i` into `data_o`. The output is therefore the input word delayed by one clock.
- R3: At the first edge where the registered drive level is 0 and the level registered before it was 1, `data_o` takes `trig_i`. After that it holds, unchanged, while the registered level stays 0 (modes 0, 2 and 3).
- R4: With `mode_i`=1 (fan-out), `data_o` loads `trig_i` at every edge, regardless of the latch strobe.
- R5: `sum_o` is the OR of all bits of `trig_i`, with no register in the path.
- R6: With `mode_i` 0, 1 or 3, `sum_held_o` loads `|trig_i` at the edge after the first edge at which `glob_stb_i` is sampled 1 following a 0. Otherwise it holds.
- R7: At any edge where `glob_clr_i` is 1, `sum_held_o` becomes 0. It stays 0 while the clear is held, and the clear wins over a simultaneous capture.
- R8: With `mode_i`=2 (held sum), `sum_held_o` loads `|trig_i` at the same edge at which `data_o` takes its snapshot (R3). In this mode `glob_stb_i` has no effect.
- R9: `led_o` is 0 while `blank_i` is 1. Otherwise bit 0 is the registered drive level, bit 1 is `sum_o` and bit 2 is `sum_held_o`.
- R10: With `gate_sum_i`=1 and an all-zero input word, a high `latch_stb_i` gives a drive level of 0. The data then holds instead of following.
- R11: `mode_i`=3 behaves exactly as `mode_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | 0 strobed, 1 fan-out, 2 held sum, 3 as 0 |
| gate_sum_i | input | 1 | Gate the latch strobe with the OR sum |
| trig_i | input | W | Trigger input word |
| latch_stb_i | input | 1 | Latch strobe: high follows, falling edge snapshots |
| glob_stb_i | input | 1 | Global strobe; rising edge captures the OR sum |
| glob_clr_i | input | 1 | Level clear of the held OR sum |
| blank_i | input | 1 | Blank the indicator outputs |
| data_o | output | W | Latched or followed trigger word |
| sum_o | output | 1 | Live OR of the trigger word |
| sum_held_o | output | 1 | Held OR of the trigger word |
| led_o | output | 3 | Indicators: drive level, live sum, held sum |

## Verification
The hardest situation to reach is the held-sum snapshot, where the trigger word is nonzero at exactly the edge the registered drive level falls. A clear must not land on that same edge, and in gated operation the strobe itself is suppressed whenever the word is empty. Directed sequences place a known word at the falling edge in each mode, with and without a coincident clear or global strobe. Random phases then drive sparse words, several of them all-zero, against strobes that toggle often, so falls and rises occur under every mode and gate setting.

// File: rtl/trl_pkg.sv
package trl_pkg;
  typedef enum logic [1:0] {
    MD_STROBED = 2'd0,
    MD_FANOUT  = 2'd1,
    MD_SUMHOLD = 2'd2,
    MD_ALT     = 2'd3
  } trl_mode_e;

  localparam int LED_W = 3;

  function automatic logic is_fanout(input logic [1:0] m);
    return trl_mode_e'(m) == MD_FANOUT;
  endfunction

  function automatic logic is_sumhold(input logic [1:0] m);
    return trl_mode_e'(m) == MD_SUMHOLD;
  endfunction

  // effective latch drive: optionally qualified by the OR sum
  function automatic logic drive_of(input logic stb, input logic gate, input logic any);
    return stb & (any | ~gate);
  endfunction
endpackage

// File: rtl/trl_edge.sv
module trl_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic cur_q, prv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= 1'b0;
      prv_q <= 1'b0;
    end else begin
      cur_q <= lvl_i;
      prv_q <= cur_q;
    end
  end

  assign lvl_o  = cur_q;
  assign rise_o = cur_q & ~prv_q;
  assign fall_o = prv_q & ~cur_q;
endmodule

// File: rtl/trl_data_hold.sv
module trl_data_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)       q_r <= '0;
    else if (en_i) q_r <= d_i;
  end

  assign q_o = q_r;
endmodule

// File: rtl/trl_sum_hold.sv
module trl_sum_hold (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic cap_i,
  input  logic d_i,
  output logic q_o
);
  logic q_r;

  always_ff @(posedge clk) begin
    if (rst || clr_i) q_r <= 1'b0;
    else if (cap_i)   q_r <= d_i;
  end

  assign q_o = q_r;
endmodule

// File: rtl/trig_latch_sum.sv
module trig_latch_sum #(
  parameter int W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 mode_i,
  input  logic                       gate_sum_i,
  input  logic [W-1:0]               trig_i,
  input  logic                       latch_stb_i,
  input  logic                       glob_stb_i,
  input  logic                       glob_clr_i,
  input  logic                       blank_i,
  output logic [W-1:0]               data_o,
  output logic                       sum_o,
  output logic                       sum_held_o,
  output logic [trl_pkg::LED_W-1:0]  led_o
);
  import trl_pkg::*;

  // named internal events, visible to the bound checker
  logic any_set;
  logic drive_now;
  logic drive_lvl, drive_rise, drive_fall;
  logic glob_lvl, glob_rise, glob_fall;
  logic data_en, sum_cap;

  assign any_set   = |trig_i;
  assign drive_now = drive_of(latch_stb_i, gate_sum_i, any_set);

  trl_edge u_drive (
    .clk(clk), .rst(rst), .lvl_i(drive_now),
    .lvl_o(drive_lvl), .rise_o(drive_rise), .fall_o(drive_fall)
  );

  trl_edge u_glob (
    .clk(clk), .rst(rst), .lvl_i(glob_stb_i),
    .lvl_o(glob_lvl), .rise_o(glob_rise), .fall_o(glob_fall)
  );

  assign data_en = is_fanout(mode_i) | drive_lvl | drive_fall;
  assign sum_cap = is_sumhold(mode_i) ? drive_fall : glob_rise;

  trl_data_hold #(.W(W)) u_data (
    .clk(clk), .rst(rst), .en_i(data_en), .d_i(trig_i), .q_o(data_o)
  );

  trl_sum_hold u_sum (
    .clk(clk), .rst(rst), .clr_i(glob_clr_i), .cap_i(sum_cap),
    .d_i(any_set), .q_o(sum_held_o)
  );

  assign sum_o = any_set;
  assign led_o = blank_i ? '0 : {sum_held_o, any_set, drive_lvl};

  logic unused_ok;
  assign unused_ok = drive_rise ^ glob_lvl ^ glob_fall;
endmodule

// File: rtl/trl_checks.sv
module trl_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode_i,
  input logic [W-1:0] trig_i,
  input logic         glob_clr_i,
  input logic [W-1:0] data_o,
  input logic         sum_held_o,
  input logic         drive_lvl,
  input logic         drive_fall
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (data_o == '0) && !sum_held_o); // R1

  AST_FOLLOW_HIGH: assert property (@(posedge clk) disable iff (rst)
    drive_lvl |=> data_o == $past(trig_i)); // R2

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    (!drive_lvl && !drive_fall && mode_i != 2'd1) |=> $stable(data_o)); // R3

  AST_FANOUT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1) |=> data_o == $past(trig_i)); // R4

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    glob_clr_i |=> !sum_held_o); // R7

  AST_SUMHOLD_MATCH: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd2 && drive_fall && !glob_clr_i) |=> sum_held_o == (|data_o)); // R8
endmodule

bind trig_latch_sum trl_checks #(.W(W)) u_checks (
  .clk(clk), .rst(rst), .mode_i(mode_i), .trig_i(trig_i),
  .glob_clr_i(glob_clr_i), .data_o(data_o), .sum_held_o(sum_held_o),
  .drive_lvl(drive_lvl), .drive_fall(drive_fall)
);

// File: tb/trig_latch_sum_test.sv
module trig_latch_sum_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   mode_i;
  logic         gate_sum_i;
  logic [W-1:0] trig_i;
  logic         latch_stb_i, glob_stb_i, glob_clr_i, blank_i;
  logic [W-1:0] data_o;
  logic         sum_o, sum_held_o;
  logic [2:0]   led_o;

  trig_latch_sum #(.W(W)) uut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .gate_sum_i(gate_sum_i),
    .trig_i(trig_i), .latch_stb_i(latch_stb_i), .glob_stb_i(glob_stb_i),
    .glob_clr_i(glob_clr_i), .blank_i(blank_i), .data_o(data_o),
    .sum_o(sum_o), .sum_held_o(sum_held_o), .led_o(led_o)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // reference state, kept in the bench's own terms
  logic         r_lvl = 0, r_old = 0, r_g = 0, r_gold = 0;
  logic [W-1:0] r_data = '0;
  logic         r_held = 0;

  function automatic logic ref_drive(logic s, logic g, logic [W-1:0] t);
    if (g && t == '0) return 1'b0;
    return s;
  endfunction

  function automatic logic [2:0] ref_led(logic b, logic h, logic s, logic l);
    if (b) return 3'b000;
    return {h, s, l};
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: update reference at the edge, compare at the falling edge
  task automatic cyc();
    logic snap, grab;
    @(posedge clk);
    if (rst) begin
      r_lvl = 0; r_old = 0; r_g = 0; r_gold = 0; r_data = '0; r_held = 0;
    end else begin
      snap = (r_old == 1'b1) && (r_lvl == 1'b0);
      if (mode_i == 2'd1 || r_lvl || snap) r_data = trig_i;
      grab = (mode_i == 2'd2) ? snap : (r_g && !r_gold);
      if (glob_clr_i) r_held = 1'b0;
      else if (grab) r_held = (trig_i != '0);
      r_old  = r_lvl;
      r_lvl  = ref_drive(latch_stb_i, gate_sum_i, trig_i);
      r_gold = r_g;
      r_g    = glob_stb_i;
    end
    @(negedge clk);
    check(tag, data_o, r_data);
    check(tag, W'(sum_held_o), W'(r_held));
    check("R5", W'(sum_o), W'(trig_i != '0));
    check("R9", W'(led_o), W'(ref_led(blank_i, r_held, trig_i != '0, r_lvl)));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; mode_i = 0; gate_sum_i = 0; trig_i = 32'hDEAD_BEEF;
    latch_stb_i = 1; glob_stb_i = 1; glob_clr_i = 0; blank_i = 0;
    @(negedge clk);
    tag = "R1"; idle(3);
    rst = 0; latch_stb_i = 0; glob_stb_i = 0; trig_i = '0; idle(2);

    // R2 follow while strobe high
    tag = "R2"; latch_stb_i = 1;
    for (int i = 0; i < 4; i++) begin trig_i = 32'h1 << (i * 7); cyc(); end
    // R3 snapshot on fall, then hold
    tag = "R3"; trig_i = 32'hA5A5_0001; latch_stb_i = 0; cyc();
    trig_i = 32'h0000_F000; cyc(); trig_i = 32'hFFFF_FFFF; idle(3);
    // R4 fan-out ignores strobe
    tag = "R4"; mode_i = 1;
    for (int i = 0; i < 4; i++) begin trig_i = ~(32'h3 << i); cyc(); end
    // R6 global strobe rise captures sum
    tag = "R6"; mode_i = 0; trig_i = 32'h8000_0000; glob_stb_i = 1; idle(3);
    trig_i = '0; idle(2); glob_stb_i = 0; idle(1);
    glob_stb_i = 1; idle(2); glob_stb_i = 0; trig_i = 32'h10; idle(2);
    // R7 clear beats coincident capture, holds while high
    tag = "R7"; glob_stb_i = 1; idle(1); glob_clr_i = 1; idle(3);
    glob_clr_i = 0; glob_stb_i = 0; idle(2);
    glob_stb_i = 1; idle(2); glob_clr_i = 1; idle(2); glob_clr_i = 0; glob_stb_i = 0;
    // R8 held sum on data snapshot; global strobe ignored
    tag = "R8"; mode_i = 2; latch_stb_i = 1; trig_i = 32'h0000_4000; idle(2);
    glob_stb_i = 1; latch_stb_i = 0; idle(1); trig_i = '0; idle(3);
    latch_stb_i = 1; idle(2); latch_stb_i = 0; idle(3); glob_stb_i = 0;
    // R9 blanking
    tag = "R9"; blank_i = 1; trig_i = 32'h7; latch_stb_i = 1; idle(3); blank_i = 0; idle(2);
    // R10 gate with sum
    tag = "R10"; mode_i = 0; gate_sum_i = 1; trig_i = 32'h55; idle(2);
    trig_i = '0; idle(3); trig_i = 32'h2; idle(2); gate_sum_i = 0; latch_stb_i = 0; idle(2);
    // R11 mode 3 like mode 0
    tag = "R11"; mode_i = 3; latch_stb_i = 1; trig_i = 32'h1234; idle(2);
    latch_stb_i = 0; trig_i = 32'h9999; idle(2); glob_stb_i = 1; idle(3); glob_stb_i = 0;

    // random phase
    tag = "R2";
    for (int k = 0; k < 3000; k++) begin
      if (k % 25 == 0) begin mode_i = 2'($urandom); gate_sum_i = ($urandom % 4 == 0); end
      trig_i = ($urandom % 3 == 0) ? '0 : ($urandom & $urandom);
      if ($urandom % 3 == 0) latch_stb_i = ~latch_stb_i;
      if ($urandom % 4 == 0) glob_stb_i = ~glob_stb_i;
      glob_clr_i = ($urandom % 10 == 0);
      blank_i = ($urandom % 8 == 0);
      rst = ($urandom % 500 == 0);
      cyc();
    end
    rst = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule